// File: doc/BRIEF.md
# Multi-Lane Direct Digital Synthesizer with Sync Gating

This block synthesizes a sine wave for a converter whose sample clock runs a whole number of times faster than the core clock. On every core clock cycle it delivers `LANES` samples side by side, one for each sample-clock slot in that core cycle. Each lane reads its own phase, and neighbouring lanes are one tuning word apart. The shared accumulator therefore advances by `LANES` times the tuning word on each valid cycle. A signed sine table with a linear output scale converts each lane's phase into an amplitude.

A sync input holds the synthesizer in a known state. While sync is active, every output sample is zero and the output valid flag stays low. The phase restarts from zero only when sync is released. A sync pulse shorter than `LANES` core cycles is stretched internally, so that every lane starts from a clean, common phase. The valid input is masked whenever the internal sync is active. The valid output is this masked valid, delayed to match the table pipeline.

Top module: `mdds_gen`

## Requirements
- R1: While reset is asserted and directly after it, `samples_out` is all zero and `valid_out` is low.
- R2: On the first valid cycle after sync release, lane k (bits k*AMP_W and up of `samples_out`) carries the phase k·`tune_word` (mod 2^PHASE_W).
- R3: On each valid cycle taken outside sync, all lane phases advance by LANES·`tune_word` (mod 2^PHASE_W). A cycle with `valid_in` low leaves the phase unchanged, and the samples repeat.
- R4: A lane sample equals round((2^(AMP_W-1)-1)·sin(2π·a/2^ADDR_W)), where a is the top ADDR_W bits of the lane phase.
- R5: While the internal sync is active, every lane sample is zero.
- R6: `valid_out` is low for every cycle whose internal sync is active, whatever the state of `valid_in`.
- R7: A sync pulse shorter than MIN_SYNC cycles keeps the internal sync active for exactly MIN_SYNC cycles.
- R8: A sync pulse of MIN_SYNC cycles or more is not lengthened. The first cycle after it already restarts the phase.
- R9: Samples and `valid_out` for the inputs of cycle n appear on the outputs after the clock edge of cycle n+1, a latency of two edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tune_word | input | PHASE_W | Phase step per sample slot |
| sync_in | input | 1 | Hold-and-restart request, active high |
| valid_in | input | 1 | Advance enable for the accumulator |
| samples_out | output | LANES*AMP_W | Packed signed samples, lane 0 in the low bits |
| valid_out | output | 1 | Masked valid, delayed to match the samples |

## Verification
Every result is due two edges after the inputs that caused it. The first edge registers the lane addresses and the gating flags, and the second registers the table read. The bench drives one cycle per call and samples 1 ns after the edge. It therefore compares each observation with the inputs it applied one call earlier. For a stretched pulse, the zero window is counted from the pulse edge plus one. The restart sample is expected exactly MIN_SYNC+1 observations after the pulse, and the bench checks that slot exactly.

// File: rtl/mdds_pkg.sv
package mdds_pkg;

   // Rounded signed sine code for table entry idx of a 2**addr_w table
   function automatic int sine_code(input int idx, input int addr_w, input int amp_w);
      real ang;
      real val;
      ang = 6.283185307179586 * idx / (2.0 ** addr_w);
      val = ((2.0 ** (amp_w - 1)) - 1.0) * $sin(ang);
      if (val >= 0.0) return $rtoi(val + 0.5);
      else            return -$rtoi(-val + 0.5);
   endfunction

endpackage

// File: rtl/mdds_sync_stretch.sv
module mdds_sync_stretch #(
   parameter int MIN_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   output logic sync_eff
);
   localparam int CNT_W = $clog2(MIN_LEN + 1);
   localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_LEN);

   logic             active_q;
   logic [CNT_W-1:0] run_q;

   always_comb sync_eff = sync_in | (active_q & (run_q < MIN_CNT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         run_q    <= '0;
      end else begin
         active_q <= sync_eff;
         if (!sync_eff)          run_q <= '0;
         else if (!active_q)     run_q <= CNT_W'(1);
         else if (run_q != MIN_CNT) run_q <= run_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/mdds_phase_acc.sv
module mdds_phase_acc #(
   parameter int LANES   = 4,
   parameter int PHASE_W = 16,
   parameter int ADDR_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [PHASE_W-1:0]        tune_word,
   input  logic                      hold_zero,
   input  logic                      advance,
   output logic [LANES*ADDR_W-1:0]   lane_addr
);
   localparam int SHIFT = PHASE_W - ADDR_W;

   logic [PHASE_W-1:0] base_q;
   logic [PHASE_W-1:0] step;

   always_comb step = tune_word * PHASE_W'(LANES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         base_q <= '0;
      else if (hold_zero) base_q <= '0;
      else if (advance)   base_q <= base_q + step;
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign lane_addr[k*ADDR_W +: ADDR_W] =
         ADDR_W'((base_q + tune_word * PHASE_W'(k)) >> SHIFT);
   end
endmodule

// File: rtl/mdds_sine_lane.sv
module mdds_sine_lane
   import mdds_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int AMP_W  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     force_zero,
   output logic signed [AMP_W-1:0]  sample
);
   localparam int DEPTH = 2 ** ADDR_W;

   logic signed [AMP_W-1:0] rom [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_rom
      localparam int CODE = sine_code(i, ADDR_W, AMP_W);
      assign rom[i] = CODE[AMP_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sample <= '0;
      else if (force_zero) sample <= '0;
      else                 sample <= rom[addr];
   end
endmodule

// File: rtl/mdds_gen.sv
module mdds_gen #(
   parameter int LANES    = 4,
   parameter int PHASE_W  = 16,
   parameter int ADDR_W   = 8,
   parameter int AMP_W    = 16,
   parameter int MIN_SYNC = LANES
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [PHASE_W-1:0]       tune_word,
   input  logic                     sync_in,
   input  logic                     valid_in,
   output logic [LANES*AMP_W-1:0]   samples_out,
   output logic                     valid_out
);
   if (LANES < 1)                    begin : g_bad_lanes $error("LANES must be at least 1"); end
   if (ADDR_W < 2 || ADDR_W > 12)    begin : g_bad_addr  $error("ADDR_W out of range 2..12"); end
   if (PHASE_W < ADDR_W)             begin : g_bad_phase $error("PHASE_W must cover ADDR_W"); end
   if (AMP_W < 2 || AMP_W > 31)      begin : g_bad_amp   $error("AMP_W out of range 2..31"); end
   if (MIN_SYNC < 1)                 begin : g_bad_sync  $error("MIN_SYNC must be at least 1"); end

   logic                         sync_eff;
   logic                         advance;
   logic [LANES*ADDR_W-1:0]      lane_addr;
   logic [LANES-1:0][ADDR_W-1:0] addr_q;
   logic                         zero_q;
   logic                         vld_q;

   mdds_sync_stretch #(.MIN_LEN(MIN_SYNC)) u_stretch (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_in  (sync_in),
      .sync_eff (sync_eff)
   );

   always_comb advance = valid_in & ~sync_eff;

   mdds_phase_acc #(.LANES(LANES), .PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .tune_word (tune_word),
      .hold_zero (sync_eff),
      .advance   (advance),
      .lane_addr (lane_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q    <= '0;
         zero_q    <= 1'b1;
         vld_q     <= 1'b0;
         valid_out <= 1'b0;
      end else begin
         addr_q    <= lane_addr;
         zero_q    <= sync_eff;
         vld_q     <= advance;
         valid_out <= vld_q;
      end
   end

   for (genvar k = 0; k < LANES; k++) begin : g_out
      logic signed [AMP_W-1:0] smp;
      mdds_sine_lane #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .addr       (addr_q[k]),
         .force_zero (zero_q),
         .sample     (smp)
      );
      assign samples_out[k*AMP_W +: AMP_W] = smp;
   end
endmodule

// File: rtl/mdds_gen_chk.sv
module mdds_gen_chk #(
   parameter int LANES    = 4,
   parameter int PHASE_W  = 16,
   parameter int AMP_W    = 16,
   parameter int MIN_SYNC = LANES
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [PHASE_W-1:0]      tune_word,
   input logic                    sync_in,
   input logic                    valid_in,
   input logic                    sync_eff,
   input logic [LANES*AMP_W-1:0]  samples_out,
   input logic                    valid_out
);
   logic [2:0]  cyc_q;
   logic [15:0] hi_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q    <= '0;
         hi_run_q <= '0;
      end else begin
         if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
         if (!sync_eff)               hi_run_q <= '0;
         else if (hi_run_q != 16'hFFFF) hi_run_q <= hi_run_q + 16'd1;
      end
   end

   p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q >= 3'd2 && $past(sync_eff, 2)) |-> (samples_out == '0));

   p_novalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q >= 3'd2 && $past(sync_eff, 2)) |-> !valid_out);

   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q >= 3'd2) |-> (valid_out == ($past(valid_in, 2) && !$past(sync_eff, 2))));

   p_min_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q >= 3'd1 && $fell(sync_eff)) |-> (hi_run_q >= 16'(MIN_SYNC)));

   p_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sync_in |-> sync_eff);

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q >= 3'd4 && !$past(valid_in, 2) && !$past(valid_in, 3) &&
       !$past(sync_eff, 2) && !$past(sync_eff, 3) &&
       $past(tune_word, 2) == $past(tune_word, 3)) |-> $stable(samples_out));
endmodule

bind mdds_gen mdds_gen_chk #(
   .LANES(LANES), .PHASE_W(PHASE_W), .AMP_W(AMP_W), .MIN_SYNC(MIN_SYNC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tune_word   (tune_word),
   .sync_in     (sync_in),
   .valid_in    (valid_in),
   .sync_eff    (sync_eff),
   .samples_out (samples_out),
   .valid_out   (valid_out)
);

// File: tb/mdds_gen_tb.sv
module mdds_gen_tb;
   localparam int L  = 4;
   localparam int PW = 16;
   localparam int AW = 8;
   localparam int MW = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PW-1:0]   tune_word = '0;
   logic            sync_in = 1'b0;
   logic            valid_in = 1'b0;
   logic [L*MW-1:0] samples_out;
   logic            valid_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   mdds_gen u_dut (
      .clk(clk), .rst_n(rst_n), .tune_word(tune_word), .sync_in(sync_in),
      .valid_in(valid_in), .samples_out(samples_out), .valid_out(valid_out)
   );

   function automatic int exp_sine(input int phase);
      real v;
      int  a;
      a = (phase & 16'hFFFF) >> (PW - AW);
      v = 32767.0 * $sin(6.283185307179586 * a / 256.0);
      if (v >= 0.0) return $rtoi(v + 0.5);
      else          return -$rtoi(-v + 0.5);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one core cycle: drive, clock, then sample 1 ns after the edge
   task automatic tick(input bit s, input bit v);
      sync_in  = s;
      valid_in = v;
      @(posedge clk);
      #1;
   endtask

   task automatic chk_lanes(input int idx, input bit vexp, input string req);
      for (int k = 0; k < L; k++) begin
         int e;
         int a;
         e = exp_sine((idx * L + k) * int'(tune_word));
         a = int'($signed(samples_out[k*MW +: MW]));
         check(a == e, req, $sformatf("lane %0d idx %0d", k, idx), a, e);
      end
      check(valid_out == vexp, req, "valid_out", int'(valid_out), int'(vexp));
   endtask

   task automatic chk_zero(input string req);
      check(samples_out == '0, req, "samples zero", int'(samples_out != '0), 0);
      check(valid_out == 1'b0, req, "valid low", int'(valid_out), 0);
   endtask

   task automatic t_reset();
      repeat (3) @(posedge clk);
      #1;
      chk_zero("R1");
      rst_n = 1'b1;
      tick(0, 0);
      chk_zero("R1");
   endtask

   task automatic t_sync_zero();
      tune_word = 16'h0350;
      tick(1, 1);
      for (int i = 0; i < 5; i++) begin
         tick(1, 1);
         chk_zero("R5");
         check(valid_out == 1'b0, "R6", "valid during sync", int'(valid_out), 0);
      end
   endtask

   task automatic t_run_hold();
      tick(0, 1);                      // release
      chk_zero("R9");                  // still shows a sync cycle
      for (int j = 0; j < 8; j++) begin
         tick(0, 1);
         chk_lanes(j, 1'b1, j == 0 ? "R2" : "R3");
      end
      tick(0, 0); chk_lanes(8, 1'b1, "R4");
      tick(0, 0); chk_lanes(9, 1'b0, "R3");
      tick(0, 0); chk_lanes(9, 1'b0, "R3");
      tick(0, 1); chk_lanes(9, 1'b0, "R9");
      tick(0, 1); chk_lanes(9, 1'b1, "R3");
      tick(0, 1); chk_lanes(10, 1'b1, "R3");
   endtask

   task automatic t_short_pulse();
      tick(1, 1);
      for (int r = 0; r < L; r++) begin
         tick(0, 1);
         chk_zero("R7");
      end
      tick(0, 1); chk_lanes(0, 1'b1, "R7");
      tick(0, 1); chk_lanes(1, 1'b1, "R7");
   endtask

   task automatic t_long_pulse();
      tick(1, 1);
      tune_word = 16'hF00F;
      for (int r = 0; r < 5; r++) begin
         tick(1, 1);
         chk_zero("R5");
      end
      tick(0, 1); chk_zero("R8");
      tick(0, 1); chk_lanes(0, 1'b1, "R8");
      tick(0, 1); chk_lanes(1, 1'b1, "R3");
      tick(0, 1); chk_lanes(2, 1'b1, "R3");
   endtask

   task automatic t_valid_gate();
      tick(1, 0);
      tune_word = 16'h1234;
      for (int r = 0; r < 6; r++) begin
         tick(1, r[0]);
         check(valid_out == 1'b0, "R6", "masked valid", int'(valid_out), 0);
      end
      tick(0, 1); check(valid_out == 1'b0, "R6", "valid at release", int'(valid_out), 0);
      tick(0, 0); chk_lanes(0, 1'b1, "R2");
      tick(0, 1); chk_lanes(1, 1'b0, "R3");
      tick(0, 0); chk_lanes(1, 1'b1, "R3");
      tick(0, 0); chk_lanes(2, 1'b0, "R3");
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_sync_zero();
      t_run_hold();
      t_short_pulse();
      t_long_pulse();
      t_valid_gate();
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule